// File: doc/BRIEF.md
# Acquisition Start Trigger Controller

This block sits in front of a converter's conversion-pulse generator and decides when those pulses may pass. A start strobe either opens the gate at once or arms the block to wait on a digital trigger line. The trigger line arrives asynchronously and is synchronised to the system clock inside the block. Once armed, the block reacts to edges or levels on that line, in the direction chosen at start time.

Edge triggers latch: the first qualifying edge after arming opens the gate, and it stays open until a stop. Level triggers gate continuously: conversion runs while the line sits at the active level, pauses while it does not, and resumes by itself. A stop strobe always returns the block to idle. The ports are plain control and status signals. No data passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `acq_trigger_ctrl`

## Requirements
- R1: With `cfg_src`=0 (software), a `start_i` sampled in idle drives `acq_en` high and `waiting` low after that same clock edge, whatever the trigger line does.
- R2: With `cfg_src`=1 (external), a `start_i` sampled in idle only arms the block. In edge mode `waiting` is high and `acq_en` low until the trigger condition is met.
- R3: `cfg_kind`=0 selects edge mode. `cfg_dir`=0 fires on a falling edge, 1 on a rising edge, and 2 or 3 on either edge. An edge of the wrong polarity leaves the block waiting.
- R4: After an edge has fired, further changes on the trigger line leave `acq_en` high and `waiting` low until a stop.
- R5: In idle, `acq_en` and `waiting` are both low. Trigger edges and levels seen before the start strobe have no effect on the outcome after arming.
- R6: `cfg_kind`=1 selects level mode. With `cfg_dir`=0 the active level is low, and with `cfg_dir`=1 it is high. `acq_en` is high while the synchronised line is active and low otherwise, `waiting` is the inverse, and conversion resumes on its own when the level returns.
- R7: Level mode with `cfg_dir`=2 or 3 behaves exactly like the software start: `acq_en` is high from the start onward and `waiting` is low.
- R8: A `stop_i` sampled at a clock edge forces idle after that edge (`acq_en`=0, `waiting`=0). It wins over a `start_i` or a trigger in the same cycle.
- R9: A `start_i` outside idle is ignored. The configuration is captured at start, so later changes on `cfg_*` have no effect until the next stop and start.
- R10: The trigger line passes through a two-flop synchroniser. A change captured at clock edge k shows on `acq_en` after edge k+1 in level mode and after edge k+2 in edge mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, one cycle |
| stop_i | input | 1 | Stop strobe, returns the block to idle |
| trig_in | input | 1 | Asynchronous digital trigger line |
| cfg_src | input | 1 | 0 software start, 1 external trigger |
| cfg_kind | input | 1 | 0 edge, 1 level |
| cfg_dir | input | 2 | 0 falling/low, 1 rising/high, 2 or 3 both |
| acq_en | output | 1 | Gate for the conversion-pulse generator |
| waiting | output | 1 | Armed and waiting for the trigger condition |

## Verification
Two functions can fall in the same cycle: a stop strobe together with a start strobe, and a stop strobe while a level or edge trigger is active. The bench provokes the first by raising `start_i` and `stop_i` in the same cycle while idle and requires both outputs to stay low. It provokes the second by stopping a running acquisition while the trigger line is held active and requires idle on the next sample. Edge latching and level pausing are told apart by moving the line after the fire and checking whether the gate follows.

// File: rtl/acq_trig_pkg.sv
package acq_trig_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_GATED = 2'd3
  } trig_state_e;

  localparam logic [1:0] DIR_FALL = 2'd0;
  localparam logic [1:0] DIR_RISE = 2'd1;

  localparam logic SRC_SOFT  = 1'b0;
  localparam logic KIND_EDGE = 1'b0;

endpackage

// File: rtl/acq_trig_sync.sv
module acq_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic prev_o
);
  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[CHAIN_W-2:0], async_i};
  end

  assign level_o = chain_q[STAGES-1];
  assign prev_o  = chain_q[STAGES];
endmodule

// File: rtl/acq_trig_qual.sv
module acq_trig_qual
  import acq_trig_pkg::*;
(
  input  logic       level_i,
  input  logic       prev_i,
  input  logic [1:0] dir_i,
  output logic       edge_hit_o,
  output logic       level_act_o
);
  logic rise, fall;

  assign rise = level_i & ~prev_i;
  assign fall = ~level_i & prev_i;

  always_comb begin
    case (dir_i)
      DIR_FALL: begin edge_hit_o = fall; level_act_o = ~level_i; end
      DIR_RISE: begin edge_hit_o = rise; level_act_o = level_i;  end
      default:  begin edge_hit_o = rise | fall; level_act_o = 1'b1; end
    endcase
  end
endmodule

// File: rtl/acq_trig_core.sv
module acq_trig_core
  import acq_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       cfg_src,
  input  logic       cfg_kind,
  input  logic [1:0] cfg_dir,
  input  logic       edge_hit_i,
  input  logic       level_act_i,
  output logic [1:0] dir_q_o,
  output logic       acq_en_o,
  output logic       waiting_o
);
  trig_state_e state_q, state_d;
  logic [1:0]  dir_q;
  logic        launch;

  assign launch = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        if (cfg_src == SRC_SOFT)        state_d = ST_RUN;
        else if (cfg_kind == KIND_EDGE) state_d = ST_ARMED;
        else if (cfg_dir[1])            state_d = ST_RUN;
        else                            state_d = ST_GATED;
      end
      ST_ARMED: if (edge_hit_i) state_d = ST_RUN;
      ST_RUN:   state_d = ST_RUN;
      ST_GATED: state_d = ST_GATED;
    endcase
    if (stop_i) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dir_q   <= DIR_FALL;
    end else begin
      state_q <= state_d;
      if (launch) dir_q <= cfg_dir;
    end
  end

  assign dir_q_o   = dir_q;
  assign acq_en_o  = (state_q == ST_RUN) || ((state_q == ST_GATED) && level_act_i);
  assign waiting_o = (state_q == ST_ARMED) || ((state_q == ST_GATED) && !level_act_i);

  // R8
  stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (!acq_en_o && !waiting_o));

  // R1
  soft_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !stop_i && cfg_src == SRC_SOFT) |=> acq_en_o);

  // R3
  edge_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARMED && edge_hit_i && !stop_i) |=> (acq_en_o && !waiting_o));

  // R4
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && !stop_i) |=> acq_en_o);

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !start_i) |=> (!acq_en_o && !waiting_o));

  // R6
  gate_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acq_en_o, waiting_o}));
endmodule

// File: rtl/acq_trigger_ctrl.sv
module acq_trigger_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       trig_in,
  input  logic       cfg_src,
  input  logic       cfg_kind,
  input  logic [1:0] cfg_dir,
  output logic       acq_en,
  output logic       waiting
);
  logic       trig_lvl, trig_prev;
  logic       edge_hit, level_act;
  logic [1:0] dir_q;

  acq_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (trig_in),
    .level_o (trig_lvl),
    .prev_o  (trig_prev)
  );

  acq_trig_qual u_qual (
    .level_i     (trig_lvl),
    .prev_i      (trig_prev),
    .dir_i       (dir_q),
    .edge_hit_o  (edge_hit),
    .level_act_o (level_act)
  );

  acq_trig_core u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .cfg_src     (cfg_src),
    .cfg_kind    (cfg_kind),
    .cfg_dir     (cfg_dir),
    .edge_hit_i  (edge_hit),
    .level_act_i (level_act),
    .dir_q_o     (dir_q),
    .acq_en_o    (acq_en),
    .waiting_o   (waiting)
  );
endmodule

// File: tb/acq_trigger_ctrl_bench.sv
module acq_trigger_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, stop_i = 1'b0, trig_in = 1'b0;
  logic cfg_src = 1'b0, cfg_kind = 1'b0;
  logic [1:0] cfg_dir = 2'd0;
  logic acq_en, waiting;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  acq_trigger_ctrl u_acq_trigger_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .trig_in(trig_in), .cfg_src(cfg_src), .cfg_kind(cfg_kind),
    .cfg_dir(cfg_dir), .acq_en(acq_en), .waiting(waiting)
  );

  // {src, kind, dir[1:0], pre, post, en_armed, wait_armed, en_after, wait_after}
  localparam logic [9:0] VEC [12] = '{
    10'b0_0_01_0_1_1010,
    10'b1_0_01_0_1_0110,
    10'b1_0_01_1_0_0101,
    10'b1_0_00_1_0_0110,
    10'b1_0_00_0_1_0101,
    10'b1_0_10_0_1_0110,
    10'b1_0_10_1_0_0110,
    10'b1_1_01_0_1_0110,
    10'b1_1_01_1_0_1001,
    10'b1_1_00_1_0_0110,
    10'b1_1_00_0_1_1001,
    10'b1_1_10_0_1_1010
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic exp_en, input logic exp_w);
    n_chk++;
    if (acq_en !== exp_en || waiting !== exp_w) begin
      n_fail++;
      $display("FAIL %s: acq_en/waiting = %b/%b, expected %b/%b",
               req, acq_en, waiting, exp_en, exp_w);
    end
  endtask

  task automatic pulse_start();
    start_i = 1'b1; tick(1); start_i = 1'b0;
  endtask

  task automatic pulse_stop();
    stop_i = 1'b1; tick(1); stop_i = 1'b0;
  endtask

  function automatic string tag_of(input logic [9:0] v);
    if (!v[9])      return "R1";
    if (!v[8])      return "R3";
    if (v[7])       return "R7";
    return "R6";
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    chk("R5 reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    tick(2);
    chk("R5 reset", 1'b0, 1'b0);

    for (int i = 0; i < 12; i++) begin
      logic [9:0] v;
      v = VEC[i];
      cfg_src = v[9]; cfg_kind = v[8]; cfg_dir = v[7:6];
      trig_in = ~v[5];
      tick(4);
      trig_in = v[5];   // activity before arming, R5
      tick(4);
      chk("R5 idle", 1'b0, 1'b0);
      pulse_start();
      tick(3);
      chk(v[9] ? "R2 armed" : "R1", v[3], v[2]);
      trig_in = v[4];
      tick(4);
      chk(tag_of(v), v[1], v[0]);
      pulse_stop();
      chk("R8 stop", 1'b0, 1'b0);
    end

    // R4: edge latch survives further activity
    cfg_src = 1'b1; cfg_kind = 1'b0; cfg_dir = 2'd1; trig_in = 1'b0;
    tick(4);
    pulse_start(); tick(2);
    trig_in = 1'b1; tick(4);
    trig_in = 1'b0; tick(4);
    chk("R4 latched", 1'b1, 1'b0);
    trig_in = 1'b1; tick(2); trig_in = 1'b0; tick(4);
    chk("R4 latched", 1'b1, 1'b0);
    pulse_stop();

    // R6: level pause and resume
    cfg_kind = 1'b1; cfg_dir = 2'd1; trig_in = 1'b0; tick(4);
    pulse_start(); tick(3);
    trig_in = 1'b1; tick(4); chk("R6 active", 1'b1, 1'b0);
    trig_in = 1'b0; tick(4); chk("R6 pause", 1'b0, 1'b1);
    trig_in = 1'b1; tick(4); chk("R6 resume", 1'b1, 1'b0);
    // R8: stop while level held active
    pulse_stop(); chk("R8 stop active", 1'b0, 1'b0);

    // R8: start and stop in the same cycle while idle
    cfg_src = 1'b0;
    start_i = 1'b1; stop_i = 1'b1; tick(1);
    start_i = 1'b0; stop_i = 1'b0;
    chk("R8 stop wins", 1'b0, 1'b0);
    tick(3); chk("R8 stop wins", 1'b0, 1'b0);

    // R9: config change after arming ignored
    cfg_src = 1'b1; cfg_kind = 1'b0; cfg_dir = 2'd1; trig_in = 1'b0; tick(4);
    pulse_start(); tick(2);
    cfg_src = 1'b0; cfg_dir = 2'd0; tick(3);
    chk("R9 cfg held", 1'b0, 1'b1);
    trig_in = 1'b1; tick(4);
    chk("R9 cfg held", 1'b1, 1'b0);
    pulse_stop();

    // R9: start while paused ignored
    cfg_src = 1'b1; cfg_kind = 1'b1; cfg_dir = 2'd1; trig_in = 1'b0; tick(4);
    pulse_start(); tick(2);
    cfg_src = 1'b0; pulse_start(); tick(3);
    chk("R9 restart ignored", 1'b0, 1'b1);
    pulse_stop();

    // R10: edge latency through the synchroniser
    cfg_src = 1'b1; cfg_kind = 1'b0; cfg_dir = 2'd1; trig_in = 1'b0; tick(4);
    pulse_start(); tick(2);
    trig_in = 1'b1;
    tick(1); chk("R10 edge k", 1'b0, 1'b1);
    tick(1); chk("R10 edge k+1", 1'b0, 1'b1);
    tick(1); chk("R10 edge k+2", 1'b1, 1'b0);
    pulse_stop();

    // R10: level latency
    cfg_kind = 1'b1; trig_in = 1'b0; tick(4);
    pulse_start(); tick(2);
    trig_in = 1'b1;
    tick(1); chk("R10 level k", 1'b0, 1'b1);
    tick(1); chk("R10 level k+1", 1'b1, 1'b0);
    pulse_stop();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule